// File: doc/BRIEF.md
# Signed Accumulate-and-Shift Averager

This block sums a stream of 24-bit converter results into a 32-bit accumulator. After a programmed number of samples it can divide the total by a power of two with a right shift, which gives an average. When that count completes it raises an interrupt. A polarity input chooses how each sample is widened to 32 bits: two's complement (sign-extended) or plain magnitude (zero-extended). The same choice decides how overflow is detected and which kind of right shift is used.

Software reaches the block through a small byte-wide register port. It sets the operating mode, the sample-count code and the shift amount in one control byte. It reads the sum one byte at a time. It can inject its own 32-bit operand: it loads three staging bytes, and the write of the lowest byte adds the whole word into the sum. Reading the lowest sum byte acknowledges the interrupt. An overflow or underflow on any add sets a sticky flag that stays set until software writes zero to it. While the converter is powered down, the block ignores all samples and register writes and holds its state.

Top module: `acc_avg_unit`

## Requirements
- R1: After reset the sum is 0, the interrupt and the overflow flag are low, and the control byte reads back 0x00.
- R2: Register map by regAddr. Address 0 is the control byte: mode in bits [7:6], count code in bits [5:3], shift in bits [2:0]. Addresses 1 to 4 read sum bytes 0 to 3, with byte 0 the least significant. Address 5 reads the overflow flag in bit 0. All other addresses read 0.
- R3: Writing 0x00 to the control byte clears the 32-bit sum and the sample count. Writing a non-zero control byte keeps the sum and restarts the count.
- R4: With unipolar=0 each sample is sign-extended from bit 23 before it is added. With unipolar=1 it is zero-extended.
- R5: In mode 1 every accepted sample is added to the sum, with no count, no shift and no interrupt.
- R6: In mode 2, count code n selects 2^(n+1) samples. The last of those samples is added, and in that same clock the result is shifted right by the shift field: arithmetic shift when unipolar=0, logical shift when unipolar=1. The interrupt is high from the next cycle. Later samples are ignored until the control byte is written again.
- R7: Mode 3 completes a count exactly as mode 2 does. The next accepted sample then starts a new sum that holds that sample alone, and counting continues.
- R8: In mode 0 samples are ignored.
- R9: Writes to addresses 2, 3 and 4 load staging bytes 1, 2 and 3. A write to address 1 adds {staging bytes 3..1, written byte} into the sum, using the same polarity rules as samples.
- R10: Reading address 1 clears the interrupt. When a count completes in the same cycle, the set wins.
- R11: The overflow flag (address 5, bit 0) is set by a two's-complement overflow on any add when unipolar=0, or by a carry out of bit 31 when unipolar=1. It stays set until address 5 is written with bit 0 = 0. Writing 1 has no effect.
- R12: While adcOff is high, samples and register writes are ignored, and the sum and the overflow flag hold.
- R13: A sample that arrives in the same cycle as any register write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcOff | input | 1 | Converter powered down; holds the block inactive |
| unipolar | input | 1 | 1 = unsigned handling, 0 = two's complement |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | 24 | Converter result |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Register read byte (combinational) |
| sumOut | output | 32 | Accumulated sum |
| doneIrq | output | 1 | Count-complete interrupt |
| ovfFlag | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the block with its default widths: a 32-bit sum, 24-bit samples, a 3-bit count code and a 3-bit shift. With these widths the longest count, 256 samples with a shift of 7, fits in a short run. Two's-complement overflow of the 32-bit sum is reached in two software adds. The unsigned carry out of bit 31 and the logical shift of a word with its top bit set are also easy to reach.

// File: rtl/acc_avg_pkg.sv
package acc_avg_pkg;
  parameter int SUM_W  = 32;
  parameter int SMP_W  = 24;
  parameter int MODE_W = 2;
  parameter int CODE_W = 3;
  parameter int SHF_W  = 3;
  parameter int ADDR_W = 3;
  localparam int NBYTES = SUM_W / 8;
  localparam int CNT_W  = (1 << CODE_W) + 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_LOOP = 2'd3
  } accMode_t;

  typedef struct packed {
    logic              clrSum;
    logic              addSample;
    logic              addStage;
    logic              freshBase;
    logic              doShift;
    logic [NBYTES-2:0] stageWr;
    logic              clrOvf;
  } accStrobe_t;
endpackage

// File: rtl/acc_avg_ctrl.sv
module acc_avg_ctrl
  import acc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcOff,
  input  logic              sampleValid,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output accStrobe_t        stb,
  output logic [7:0]        ctrlReg,
  output logic              doneIrq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;
  logic             done;
  logic             fresh;
  accMode_t         mode;
  logic [CODE_W-1:0] codeF;
  logic             wrHit, ctrlWr, takeSmp, counted, isLast;

  assign mode    = accMode_t'(ctrlReg[SHF_W+CODE_W +: MODE_W]);
  assign codeF   = ctrlReg[SHF_W +: CODE_W];
  assign lastIdx = (CNT_W'(1) << ({1'b0, codeF} + 1'b1)) - 1'b1;

  assign wrHit   = !adcOff && regWrEn;
  assign ctrlWr  = wrHit && (regAddr == '0);
  assign takeSmp = !adcOff && sampleValid && !regWrEn && (mode != MODE_IDLE)
                   && !((mode == MODE_ONCE) && done);
  assign counted = (mode == MODE_ONCE) || (mode == MODE_LOOP);
  assign isLast  = counted && (cnt == lastIdx);

  always_comb begin
    stb.clrSum    = ctrlWr && (regWrData == 8'h00);
    stb.addSample = takeSmp;
    stb.addStage  = wrHit && (regAddr == ADDR_W'(1));
    stb.freshBase = takeSmp && fresh;
    stb.doShift   = takeSmp && isLast;
    stb.clrOvf    = wrHit && (regAddr == ADDR_W'(NBYTES + 1)) && !regWrData[0];
    for (int i = 0; i < NBYTES - 1; i++)
      stb.stageWr[i] = wrHit && (regAddr == ADDR_W'(i + 2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      fresh   <= 1'b0;
    end else if (ctrlWr) begin
      ctrlReg <= regWrData;
      cnt     <= '0;
      done    <= 1'b0;
      fresh   <= 1'b0;
    end else if (takeSmp && counted) begin
      if (isLast) begin
        cnt   <= '0;
        done  <= (mode == MODE_ONCE);
        fresh <= (mode == MODE_LOOP);
      end else begin
        cnt   <= cnt + 1'b1;
        fresh <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   doneIrq <= 1'b0;
    else if (takeSmp && isLast)                  doneIrq <= 1'b1;
    else if (regRdEn && regAddr == ADDR_W'(1))   doneIrq <= 1'b0;
  end
endmodule

// File: rtl/acc_avg_dpath.sv
module acc_avg_dpath
  import acc_avg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  accStrobe_t       stb,
  input  logic             unipolar,
  input  logic [SHF_W-1:0] shAmt,
  input  logic [SMP_W-1:0] sampleData,
  input  logic [7:0]       regWrData,
  output logic [SUM_W-1:0] sumOut,
  output logic             ovfFlag
);
  logic [SUM_W-1:8] stageHi;
  logic [SUM_W-1:0] ext, addend, base, res, logicShf, arithShf, nextSum;
  logic signed [SUM_W-1:0] resS;
  logic [SUM_W:0]   wide;
  logic             ovfNow, addAny;

  assign ext    = unipolar ? {{(SUM_W-SMP_W){1'b0}}, sampleData}
                           : {{(SUM_W-SMP_W){sampleData[SMP_W-1]}}, sampleData};
  assign addend = stb.addSample ? ext : {stageHi, regWrData};
  assign base   = stb.freshBase ? '0 : sumOut;
  assign wide   = {1'b0, base} + {1'b0, addend};
  assign res    = wide[SUM_W-1:0];
  assign ovfNow = unipolar ? wide[SUM_W]
                           : (base[SUM_W-1] == addend[SUM_W-1]) && (res[SUM_W-1] != base[SUM_W-1]);
  assign resS     = res;
  assign arithShf = resS >>> shAmt;
  assign logicShf = res >> shAmt;
  assign nextSum  = !stb.doShift ? res : (unipolar ? logicShf : arithShf);
  assign addAny   = stb.addSample || stb.addStage;

  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              stageHi[8*(g+1) +: 8] <= '0;
      else if (stb.stageWr[g]) stageHi[8*(g+1) +: 8] <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sumOut <= '0;
    else if (stb.clrSum) sumOut <= '0;
    else if (addAny)     sumOut <= nextSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovfFlag <= 1'b0;
    else if (addAny && ovfNow) ovfFlag <= 1'b1;
    else if (stb.clrOvf)       ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/acc_avg_unit.sv
module acc_avg_unit
  import acc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcOff,
  input  logic              unipolar,
  input  logic              sampleValid,
  input  logic [SMP_W-1:0]  sampleData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic [SUM_W-1:0]  sumOut,
  output logic              doneIrq,
  output logic              ovfFlag
);
  accStrobe_t stb;
  logic [7:0] ctrlReg;

  acc_avg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .adcOff(adcOff), .sampleValid(sampleValid),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .stb(stb), .ctrlReg(ctrlReg), .doneIrq(doneIrq)
  );

  acc_avg_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .unipolar(unipolar),
    .shAmt(ctrlReg[SHF_W-1:0]), .sampleData(sampleData), .regWrData(regWrData),
    .sumOut(sumOut), .ovfFlag(ovfFlag)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) regRdData = ctrlReg;
    for (int i = 0; i < NBYTES; i++)
      if (regAddr == ADDR_W'(i + 1)) regRdData = sumOut[8*i +: 8];
    if (regAddr == ADDR_W'(NBYTES + 1)) regRdData = {7'b0, ovfFlag};
  end
endmodule

// File: rtl/acc_avg_chk.sv
module acc_avg_chk
  import acc_avg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              adcOff,
  input logic              sampleValid,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic [SUM_W-1:0]  sumOut,
  input logic              doneIrq,
  input logic              ovfFlag
);
  // R3
  ctrl_zero_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adcOff && regWrEn && regAddr == '0 && regWrData == 8'h00) |=> (sumOut == '0));

  // R12
  power_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcOff |=> ($stable(sumOut) && $stable(ovfFlag)));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(!adcOff && regWrEn && regAddr == ADDR_W'(NBYTES + 1) && !regWrData[0]))
    |=> ovfFlag);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(1) && !sampleValid) |=> !doneIrq);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> $past(sampleValid && !regWrEn && !adcOff));
endmodule

bind acc_avg_unit acc_avg_chk chk_i (.*);

// File: tb/acc_avg_unit_tb_top.sv
module acc_avg_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adcOff = 1'b0, unipolar = 1'b0, sampleValid = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0;
  logic [23:0] sampleData = '0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [31:0] sumOut;
  logic        doneIrq, ovfFlag;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acc_avg_unit dut_i (.*);

  // behavioural reference
  logic [31:0] mSum, mStage;
  logic [7:0]  mCtrl;
  bit mIrq, mOvf, mDone, mFresh;
  int mCnt;

  task automatic modelAdd(input longint a, input bit sh);
    longint b, s;
    logic [31:0] r;
    b = mFresh ? 64'sd0 : (unipolar ? longint'(mSum) : longint'($signed(mSum)));
    s = b + a;
    if (unipolar ? (s > 64'sh0FFFF_FFFF) : (s > 64'sd2147483647 || s < -64'sd2147483648))
      mOvf = 1'b1;
    r = s[31:0];
    if (sh) r = unipolar ? (r >> mCtrl[2:0]) : 32'($signed(r) >>> mCtrl[2:0]);
    mSum = r;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSum = '0; mStage = '0; mCtrl = '0; mIrq = 0; mOvf = 0; mDone = 0; mFresh = 0; mCnt = 0;
    end else begin
      bit lastHit;
      int md;
      lastHit = 1'b0;
      md = int'(mCtrl[7:6]);
      if (!adcOff && regWrEn) begin
        case (regAddr)
          3'd0: begin
            mCtrl = regWrData; mCnt = 0; mDone = 0; mFresh = 0;
            if (regWrData == 8'h00) mSum = '0;
          end
          3'd1: modelAdd(unipolar ? longint'({mStage[31:8], regWrData})
                                  : longint'($signed({mStage[31:8], regWrData})), 1'b0);
          3'd2: mStage[15:8]  = regWrData;
          3'd3: mStage[23:16] = regWrData;
          3'd4: mStage[31:24] = regWrData;
          3'd5: if (!regWrData[0]) mOvf = 1'b0;
          default: ;
        endcase
      end else if (!adcOff && sampleValid && md != 0 && !(md == 2 && mDone)) begin
        if (md >= 2) begin
          mCnt++;
          lastHit = (mCnt == (1 << (int'(mCtrl[5:3]) + 1)));
          if (lastHit) mCnt = 0;
        end
        modelAdd(unipolar ? longint'(sampleData) : longint'($signed(sampleData)), lastHit);
        if (lastHit) begin mDone = (md == 2); mFresh = (md == 3); end
        else mFresh = 1'b0;
      end
      if (regRdEn && regAddr == 3'd1) mIrq = 1'b0;
      if (lastHit) mIrq = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      compared++;
      if (sumOut !== mSum || doneIrq !== mIrq || ovfFlag !== mOvf) begin
        mismatched++;
        $display("FAIL %s: sum=%h irq=%0b ovf=%0b expected sum=%h irq=%0b ovf=%0b",
                 phase, sumOut, doneIrq, ovfFlag, mSum, mIrq, mOvf);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input bit rd, input bit sv, input logic [2:0] a,
                     input logic [7:0] wd, input logic [23:0] sd);
    @(negedge clk);
    regWrEn = we; regRdEn = rd; sampleValid = sv; regAddr = a; regWrData = wd; sampleData = sd;
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); cyc(1, 0, 0, a, d, '0); endtask
  task automatic smp(input logic [23:0] v);                     cyc(0, 0, 1, 3'd0, 8'h00, v); endtask
  task automatic rd(input logic [2:0] a);                       cyc(0, 1, 0, a, 8'h00, '0); endtask
  task automatic nop();                                         cyc(0, 0, 0, 3'd0, 8'h00, '0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nop();
    phase = "R1";
    chk("R1 sum", sumOut, 32'h0);
    chk("R1 irq/ovf", {30'b0, doneIrq, ovfFlag}, 32'h0);
    rd(3'd0); #1 chk("R1 ctrl readback", {24'b0, regRdData}, 32'h0);

    phase = "R5";
    wr(3'd0, 8'h40); smp(24'd5); smp(24'hFFFFFD); nop();
    chk("R5/R4 bipolar run", sumOut, 32'd2);
    phase = "R4"; unipolar = 1'b1;
    smp(24'hFFFFFD); nop();
    chk("R4 zero extend", sumOut, 32'h00FF_FFFF);
    unipolar = 1'b0;

    phase = "R3";
    wr(3'd0, 8'h00); nop(); chk("R3 clear", sumOut, 32'h0);
    wr(3'd0, 8'h40); smp(24'd7); wr(3'd0, 8'h41); nop();
    chk("R3 nonzero keeps sum", sumOut, 32'd7);

    phase = "R8";
    wr(3'd0, 8'h00); smp(24'd9); nop();
    chk("R8 idle ignores", sumOut, 32'h0);

    phase = "R6";
    wr(3'd0, 8'h8A); smp(24'd4); smp(24'd8); smp(24'd12); nop();
    chk("R6 no irq early", {31'b0, doneIrq}, 32'h0);
    smp(24'd16); nop();
    chk("R6 average", sumOut, 32'd10);
    chk("R6 irq", {31'b0, doneIrq}, 32'h1);
    smp(24'd100); nop();
    chk("R6 ignored after done", sumOut, 32'd10);
    phase = "R10";
    rd(3'd1); #1 chk("R2 byte0 read", {24'b0, regRdData}, 32'h0A);
    nop(); chk("R10 read clears irq", {31'b0, doneIrq}, 32'h0);

    phase = "R6";
    wr(3'd0, 8'h00); wr(3'd0, 8'h81); smp(24'hFFFFF8); smp(24'hFFFFF8); nop();
    chk("R6 arithmetic shift", sumOut, 32'hFFFF_FFF8);
    rd(3'd1); nop();

    phase = "R7";
    wr(3'd0, 8'h00); wr(3'd0, 8'hC0); smp(24'd3); smp(24'd5); nop();
    chk("R7 first block", sumOut, 32'd8);
    smp(24'd7); nop();
    chk("R7 restart", sumOut, 32'd7);
    smp(24'd1); nop();
    chk("R7 second block", sumOut, 32'd8);
    rd(3'd1); nop();

    phase = "R9";
    wr(3'd0, 8'h00); wr(3'd0, 8'h40);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h7F); wr(3'd1, 8'hFF); nop();
    chk("R9 soft add", sumOut, 32'h7FFF_FFFF);
    rd(3'd4); #1 chk("R2 byte3 read", {24'b0, regRdData}, 32'h7F);
    phase = "R11";
    wr(3'd1, 8'h01); nop();
    chk("R11 signed overflow", {31'b0, ovfFlag}, 32'h1);
    rd(3'd5); #1 chk("R2 flag read", {24'b0, regRdData}, 32'h1);
    wr(3'd5, 8'h01); smp(24'd1); nop();
    chk("R11 sticky", {31'b0, ovfFlag}, 32'h1);
    wr(3'd5, 8'h00); nop();
    chk("R11 cleared", {31'b0, ovfFlag}, 32'h0);
    rd(3'd7); #1 chk("R2 unused addr", {24'b0, regRdData}, 32'h0);

    phase = "R11";
    unipolar = 1'b1;
    wr(3'd0, 8'h00); wr(3'd0, 8'h40);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd1, 8'hFF); nop();
    chk("R11 no carry yet", {31'b0, ovfFlag}, 32'h0);
    smp(24'd1); nop();
    chk("R11 unsigned carry", {31'b0, ovfFlag}, 32'h1);
    chk("R11 wrapped sum", sumOut, 32'h0);
    wr(3'd5, 8'h00);

    phase = "R6";
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h80); wr(3'd1, 8'h00);
    wr(3'd0, 8'h81); smp(24'd0); smp(24'd0); nop();
    chk("R6 logical shift", sumOut, 32'h4000_0000);
    rd(3'd1);
    unipolar = 1'b0;

    phase = "R12";
    wr(3'd0, 8'h40); smp(24'd3);
    @(negedge clk) adcOff = 1'b1;
    smp(24'd5); wr(3'd0, 8'h00); wr(3'd1, 8'h11); nop();
    chk("R12 held while off", sumOut, 32'h4000_0003);
    @(negedge clk) adcOff = 1'b0;

    phase = "R13";
    cyc(1, 0, 1, 3'd2, 8'h00, 24'd5); nop();
    chk("R13 sample blocked by write", sumOut, 32'h4000_0003);

    phase = "R6";
    wr(3'd0, 8'h00); wr(3'd0, 8'hBF);
    for (int i = 0; i < 255; i++) smp(24'd3);
    nop();
    chk("R6 no irq at 255", {31'b0, doneIrq}, 32'h0);
    smp(24'd3); nop();
    chk("R6 max count average", sumOut, 32'd6);
    chk("R6 max count irq", {31'b0, doneIrq}, 32'h1);
    nop(); nop();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule